// File: doc/BRIEF.md
# Twin-Predicated Register Move Sequencer

This block turns a single register-to-register move into a stream of element copies. Either operand may be a scalar or a vector. Each vector operand carries its own predicate mask. One element cursor belongs to the source and one to the destination. Each cursor jumps over the clear bits of its own mask and leaves the other cursor alone. The operand flags and the masks alone decide which pattern results: a copy, a splat, a sparse splat, an insert, an extract, a gather, a scatter, or a gather and scatter together.

To launch a move, the issuing logic pulses `start` while the block is idle. The block presents at most one copy request per cycle as a pair of register indices: the register to read and the register to write. It flags the end of the move with a one-cycle `done` pulse and then goes idle again. Access to the register file and the lookup of the masks are handled outside this block.

The state machine has three states:
- IDLE waits for `start`. With a zero length it goes straight to FIN; with any other length it goes to RUN.
- RUN issues one copy per cycle while both cursors find an element below the length. It moves to FIN in four cases: a cursor finds nothing, a cursor reaches the length after a copy, a scalar destination has received its one copy, or no copy is possible.
- FIN raises `done` for one cycle and always returns to IDLE.

Top module: `twin_pred_move_seq`

## Requirements
- R1: After reset, `busy`, `copy_valid` and `done` are all 0.
- R2: `start` is taken only in IDLE, and the operands are captured on that edge. While the block is busy, `start` and every operand input are ignored, so changing them has no effect on the copies that are issued.
- R3: When the source is a vector, each copy reads the register `src_base` plus the position of the next set bit of `src_mask`, looking at positions at or above the source cursor. Bit k of the mask belongs to element k.
- R4: When the destination is a vector, each copy writes the register `dst_base` plus the position of the next set bit of `dst_mask`, looking at positions at or above the destination cursor. Clear bits are skipped.
- R5: After a copy, a cursor moves one past the element it used only if its operand is a vector. A scalar operand always uses element 0 and ignores its mask. A scalar source with a vector destination therefore repeats the same source register for every destination element (splat).
- R6: The move ends as soon as either cursor reaches the vector length. A skip that finds no set bit below the length ends the move with no further copy. Mask bits at or above the length are never used.
- R7: A scalar destination receives exactly one copy, after which the move ends (extract). When both operands are scalar, exactly one copy is made, from `src_base` to `dst_base`.
- R8: A vector length of 0 issues no copy, and `done` is high in the first cycle after the start edge.
- R9: At most one copy request is presented per cycle, and only while busy. `done` lasts exactly one cycle and comes after the last copy. The block is idle in the cycle after `done`.
- R10: Register indices are the base plus the element offset, taken modulo 2^REG_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches a move when the block is idle |
| src_base | input | REG_W | Base register of the source |
| dst_base | input | REG_W | Base register of the destination |
| src_is_vec | input | 1 | 1 when the source is a vector |
| dst_is_vec | input | 1 | 1 when the destination is a vector |
| src_mask | input | MAX_VL | Source predicate; bit k enables element k |
| dst_mask | input | MAX_VL | Destination predicate; bit k enables element k |
| vec_len | input | LEN_W | Vector length; values above MAX_VL are clamped to MAX_VL |
| busy | output | 1 | High when the block is not idle |
| copy_valid | output | 1 | A copy request is presented this cycle |
| copy_dst | output | REG_W | Register to write |
| copy_src | output | REG_W | Register to read |
| done | output | 1 | One-cycle pulse at the end of the move |

## Verification
A cursor that is wrong internally shows up on the very next request. The index it carries is off, or a request that should be there is missing. A cursor that fails to advance repeats the same destination index on consecutive cycles. A stuck state machine lets `copy_valid` continue past the expected count, or never raises `done`. The bench compares each complete request sequence with an independent model of the two-cursor walk. Any error therefore shows up within the move in which it occurs, either as a wrong count or as a pair that differs from the model at its first divergent position.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } tpm_state_e;
endpackage

// File: rtl/tpm_next_set.sv
// Finds the element a cursor should use next.
// For a vector operand: the lowest set mask bit at or above the cursor
// and below the length. For a scalar operand: the cursor itself.
module tpm_next_set #(
    parameter int MAX_VL = 16,
    localparam int LEN_W = $clog2(MAX_VL + 1)
) (
    input  logic [MAX_VL-1:0] mask,
    input  logic [LEN_W-1:0]  cursor,
    input  logic [LEN_W-1:0]  vlen,
    input  logic              is_vec,
    output logic              found,
    output logic [LEN_W-1:0]  pos
);
    always_comb begin
        found = 1'b0;
        pos   = cursor;
        if (!is_vec) begin
            found = (cursor < vlen);
        end else begin
            // Descending scan, so the lowest qualifying bit wins.
            for (int k = MAX_VL - 1; k >= 0; k--) begin
                if (mask[k] && (k >= int'(cursor)) && (k < int'(vlen))) begin
                    found = 1'b1;
                    pos   = LEN_W'(k);
                end
            end
        end
    end
endmodule

// File: rtl/tpm_ctrl.sv
module tpm_ctrl
    import tpm_pkg::*;
#(
    parameter int MAX_VL = 16,
    parameter int REG_W  = 5,
    localparam int LEN_W = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [REG_W-1:0]  src_base,
    input  logic [REG_W-1:0]  dst_base,
    input  logic              src_is_vec,
    input  logic              dst_is_vec,
    input  logic [MAX_VL-1:0] src_mask,
    input  logic [MAX_VL-1:0] dst_mask,
    input  logic [LEN_W-1:0]  vec_len,
    // Connections to the two skip finders
    output logic [MAX_VL-1:0] s_mask_q,
    output logic [MAX_VL-1:0] d_mask_q,
    output logic [LEN_W-1:0]  s_cur_q,
    output logic [LEN_W-1:0]  d_cur_q,
    output logic [LEN_W-1:0]  vl_q,
    output logic              sv_q,
    output logic              dv_q,
    input  logic              s_found,
    input  logic [LEN_W-1:0]  s_pos,
    input  logic              d_found,
    input  logic [LEN_W-1:0]  d_pos,
    // Block outputs
    output logic              busy,
    output logic              copy_valid,
    output logic [REG_W-1:0]  copy_dst,
    output logic [REG_W-1:0]  copy_src,
    output logic              done
);
    localparam logic [LEN_W-1:0] VL_CAP = LEN_W'(MAX_VL);

    tpm_state_e       state_q, state_d;
    logic [REG_W-1:0] sb_q, db_q;
    logic [LEN_W-1:0] s_nxt, d_nxt, vl_clamped;
    logic             can_copy, last_copy;

    assign vl_clamped = (vec_len > VL_CAP) ? VL_CAP : vec_len;
    assign can_copy   = (state_q == ST_RUN) && s_found && d_found;
    assign s_nxt      = s_pos + LEN_W'(sv_q);
    assign d_nxt      = d_pos + LEN_W'(dv_q);
    assign last_copy  = !dv_q || (s_nxt >= vl_q) || (d_nxt >= vl_q);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = (vl_clamped == '0) ? ST_FIN : ST_RUN;
            ST_RUN:  if (!can_copy || last_copy) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register, operand capture and cursors
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            sb_q     <= '0;
            db_q     <= '0;
            s_mask_q <= '0;
            d_mask_q <= '0;
            sv_q     <= 1'b0;
            dv_q     <= 1'b0;
            vl_q     <= '0;
            s_cur_q  <= '0;
            d_cur_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                sb_q     <= src_base;
                db_q     <= dst_base;
                s_mask_q <= src_mask;
                d_mask_q <= dst_mask;
                sv_q     <= src_is_vec;
                dv_q     <= dst_is_vec;
                vl_q     <= vl_clamped;
                s_cur_q  <= '0;
                d_cur_q  <= '0;
            end else if (can_copy) begin
                s_cur_q <= s_nxt;
                d_cur_q <= d_nxt;
            end
        end
    end

    // Outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        copy_valid = can_copy;
        copy_src   = sb_q + REG_W'(s_pos);
        copy_dst   = db_q + REG_W'(d_pos);
        done       = (state_q == ST_FIN);
    end

    assert_copy_only_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        copy_valid |-> busy);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy && !copy_valid));
    assert_scalar_dst_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_valid && !dv_q) |=> !copy_valid);
    assert_zero_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && vl_clamped == '0) |=> (done && !copy_valid));
    assert_capture_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(sb_q) && $stable(db_q) && $stable(vl_q)));
    assert_dst_cursor_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_valid && dv_q) |=> (d_cur_q > $past(d_cur_q)));
endmodule

// File: rtl/twin_pred_move_seq.sv
module twin_pred_move_seq #(
    parameter int MAX_VL = 16,
    parameter int REG_W  = 5,
    localparam int LEN_W = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [REG_W-1:0]  src_base,
    input  logic [REG_W-1:0]  dst_base,
    input  logic              src_is_vec,
    input  logic              dst_is_vec,
    input  logic [MAX_VL-1:0] src_mask,
    input  logic [MAX_VL-1:0] dst_mask,
    input  logic [LEN_W-1:0]  vec_len,
    output logic              busy,
    output logic              copy_valid,
    output logic [REG_W-1:0]  copy_dst,
    output logic [REG_W-1:0]  copy_src,
    output logic              done
);
    logic [MAX_VL-1:0] s_mask_q, d_mask_q;
    logic [LEN_W-1:0]  s_cur_q, d_cur_q, vl_q, s_pos, d_pos;
    logic              sv_q, dv_q, s_found, d_found;

    tpm_ctrl #(.MAX_VL(MAX_VL), .REG_W(REG_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_base(src_base), .dst_base(dst_base),
        .src_is_vec(src_is_vec), .dst_is_vec(dst_is_vec),
        .src_mask(src_mask), .dst_mask(dst_mask), .vec_len(vec_len),
        .s_mask_q(s_mask_q), .d_mask_q(d_mask_q),
        .s_cur_q(s_cur_q), .d_cur_q(d_cur_q), .vl_q(vl_q),
        .sv_q(sv_q), .dv_q(dv_q),
        .s_found(s_found), .s_pos(s_pos),
        .d_found(d_found), .d_pos(d_pos),
        .busy(busy), .copy_valid(copy_valid),
        .copy_dst(copy_dst), .copy_src(copy_src), .done(done)
    );

    tpm_next_set #(.MAX_VL(MAX_VL)) src_skip_i (
        .mask(s_mask_q), .cursor(s_cur_q), .vlen(vl_q), .is_vec(sv_q),
        .found(s_found), .pos(s_pos)
    );

    tpm_next_set #(.MAX_VL(MAX_VL)) dst_skip_i (
        .mask(d_mask_q), .cursor(d_cur_q), .vlen(vl_q), .is_vec(dv_q),
        .found(d_found), .pos(d_pos)
    );
endmodule

// File: tb/twin_pred_move_seq_tb.sv
module twin_pred_move_seq_tb_top;
    localparam int MAX_VL = 16;
    localparam int REG_W  = 5;
    localparam int LEN_W  = $clog2(MAX_VL + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [REG_W-1:0]  src_base = '0, dst_base = '0;
    logic              src_is_vec = 1'b0, dst_is_vec = 1'b0;
    logic [MAX_VL-1:0] src_mask = '0, dst_mask = '0;
    logic [LEN_W-1:0]  vec_len = '0;
    logic              busy, copy_valid, done;
    logic [REG_W-1:0]  copy_dst, copy_src;

    int checks = 0;
    int failures = 0;

    int exp_n;
    int exp_d [MAX_VL+2];
    int exp_s [MAX_VL+2];
    int act_n;
    int act_d [MAX_VL+2];
    int act_s [MAX_VL+2];
    int done_cycle;

    always #10 clk = ~clk;

    twin_pred_move_seq #(.MAX_VL(MAX_VL), .REG_W(REG_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_base(src_base), .dst_base(dst_base),
        .src_is_vec(src_is_vec), .dst_is_vec(dst_is_vec),
        .src_mask(src_mask), .dst_mask(dst_mask), .vec_len(vec_len),
        .busy(busy), .copy_valid(copy_valid),
        .copy_dst(copy_dst), .copy_src(copy_src), .done(done)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Independent model of the two-cursor walk
    task automatic model(input int sb, input int db, input bit sv, input bit dv,
                         input logic [MAX_VL-1:0] sm, input logic [MAX_VL-1:0] dm,
                         input int vl);
        int i = 0;
        int j = 0;
        exp_n = 0;
        for (int guard = 0; guard < 4 * MAX_VL; guard++) begin
            if (sv) while (i < vl && !sm[i]) i++;
            if (dv) while (j < vl && !dm[j]) j++;
            if (i >= vl || j >= vl) break;
            exp_d[exp_n] = (db + j) % (1 << REG_W);
            exp_s[exp_n] = (sb + i) % (1 << REG_W);
            exp_n++;
            if (!dv) break;
            if (sv) i++;
            j++;
        end
    endtask

    task automatic run_op(input string req, input int sb, input int db,
                          input bit sv, input bit dv,
                          input logic [MAX_VL-1:0] sm, input logic [MAX_VL-1:0] dm,
                          input int vl, input bit hold);
        int cyc = 0;
        model(sb, db, sv, dv, sm, dm, vl);
        @(negedge clk);
        src_base = REG_W'(sb); dst_base = REG_W'(db);
        src_is_vec = sv; dst_is_vec = dv;
        src_mask = sm; dst_mask = dm; vec_len = LEN_W'(vl);
        start = 1'b1;
        act_n = 0;
        done_cycle = -1;
        while (cyc < 60) begin
            @(negedge clk);
            cyc++;
            if (copy_valid) begin
                if (act_n < MAX_VL + 2) begin
                    act_d[act_n] = int'(copy_dst);
                    act_s[act_n] = int'(copy_src);
                end
                act_n++;
            end
            if (done) begin
                done_cycle = cyc;
                start = 1'b0;
                break;
            end
            if (hold) begin
                // R2: inputs change while busy and start stays high
                src_base = REG_W'($urandom); dst_base = REG_W'($urandom);
                src_is_vec = 1'($urandom); dst_is_vec = 1'($urandom);
                src_mask = MAX_VL'($urandom); dst_mask = MAX_VL'($urandom);
                vec_len = LEN_W'($urandom % (MAX_VL + 1));
            end else begin
                start = 1'b0;
            end
        end
        check(req, "done seen", (done_cycle > 0) ? 1 : 0, 1);
        check(req, "copy count", act_n, exp_n);
        for (int k = 0; k < exp_n && k < act_n; k++) begin
            check(req, $sformatf("dst reg of copy %0d", k), act_d[k], exp_d[k]);
            check(req, $sformatf("src reg of copy %0d", k), act_s[k], exp_s[k]);
        end
        @(negedge clk);
        // R9: idle and quiet after done
        check("R9", "busy after done", int'(busy), 0);
        check("R9", "done width", int'(done), 0);
    endtask

    initial begin
        void'($urandom(32'd12345));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "busy in reset", int'(busy), 0);
        check("R1", "valid in reset", int'(copy_valid), 0);
        check("R1", "done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "busy after reset", int'(busy), 0);

        // R5 splat: scalar source, unpredicated vector destination
        run_op("R5", 7, 2, 1'b0, 1'b1, 16'h0000, 16'hFFFF, 8, 1'b0);
        // R3 gather into contiguous destination
        run_op("R3", 4, 20, 1'b1, 1'b1, 16'b1010_0100_1001_0010, 16'hFFFF, 16, 1'b0);
        // R4 scatter from contiguous source
        run_op("R4", 0, 8, 1'b1, 1'b1, 16'hFFFF, 16'b0000_0000_0110_0101, 12, 1'b0);
        // R4 sparse splat
        run_op("R4", 9, 1, 1'b0, 1'b1, 16'h0000, 16'b0001_0000_1000_0001, 13, 1'b0);
        // R7 extract: vector source, scalar destination
        run_op("R7", 3, 11, 1'b1, 1'b0, 16'b0000_0000_0001_0000, 16'h0000, 10, 1'b0);
        // R7 both scalar
        run_op("R7", 5, 6, 1'b0, 1'b0, 16'h0000, 16'h0000, 4, 1'b0);
        // R8 zero length, done on first cycle
        run_op("R8", 5, 6, 1'b1, 1'b1, 16'hFFFF, 16'hFFFF, 0, 1'b0);
        check("R8", "done cycle", done_cycle, 1);
        // R6 empty source mask ends with no copy
        run_op("R6", 1, 2, 1'b1, 1'b1, 16'h0000, 16'hFFFF, 9, 1'b0);
        // R6 mask bits above length ignored
        run_op("R6", 1, 2, 1'b1, 1'b1, 16'hFF00, 16'hFFFF, 8, 1'b0);
        // R6 destination runs out first
        run_op("R6", 0, 0, 1'b1, 1'b1, 16'hFFFF, 16'b0000_0000_0000_0110, 16, 1'b0);
        // R10 index wrap
        run_op("R10", 30, 28, 1'b1, 1'b1, 16'hFFFF, 16'hFFFF, 6, 1'b0);
        // R2 start held and inputs scrambled while busy
        run_op("R2", 2, 12, 1'b1, 1'b1, 16'b0101_0101_0101_0101, 16'b0011_0011_0011_0011, 16, 1'b1);

        // Constrained random mix
        for (int t = 0; t < 200; t++) begin
            run_op((t % 2) ? "R3" : "R4",
                   int'($urandom % 32), int'($urandom % 32),
                   1'($urandom), 1'($urandom),
                   MAX_VL'($urandom), MAX_VL'($urandom),
                   int'($urandom % (MAX_VL + 1)), 1'($urandom % 4 == 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule